// File: doc/BRIEF.md
# Bistable Pulse Decoder with Link Watchdog

This block is the receiving end of a channel that carries a logic level as edge events. The far side sends a "set" pulse when its input goes high and a "clear" pulse when it goes low. While its input is steady, it repeats the matching pulse at a fixed refresh interval. The decoder rebuilds the level from these pulses alone. It holds the last commanded value in a bistable register and changes it only when a pulse arrives.

A watchdog counts clock cycles that pass without any pulse. When that count reaches `TIMEOUT_CYCLES`, the far side is taken to be unpowered or broken. The decoder then forces its output to the safe low level and raises a link-lost flag. Both stay that way until a new pulse arrives. Set `TIMEOUT_CYCLES` well above the transmitter's refresh interval so that a healthy link never trips the watchdog. Example: a 5 µs timeout against a 1 µs refresh, which at 100 MHz is 500 cycles.

Top module: `isorx_pulse_decoder`

## Requirements
- R1: A cycle with `set_pulse_i`=1 and `clr_pulse_i`=0 makes `level_o` 1 on the following cycle.
- R2: A cycle with `clr_pulse_i`=1 and `set_pulse_i`=0 makes `level_o` 0 on the following cycle.
- R3: A cycle with neither pulse leaves `level_o` unchanged, unless that cycle completes a timeout (R4).
- R4: `link_lost_o` rises, and `level_o` is forced to 0, in the cycle after `TIMEOUT_CYCLES` consecutive pulse-free cycles. After `TIMEOUT_CYCLES`-1 such cycles the flag is still 0.
- R5: Any pulse (set, clear or both) makes `link_lost_o` 0 on the following cycle and restarts the idle count from zero.
- R6: A cycle with both pulses at 1 is invalid: `level_o` keeps its value, but the watchdog is still cleared as in R5.
- R7: While `rst_n` is 0 and after its release, `level_o` is 0 and `link_lost_o` is 1 until the first pulse.
- R8: While `link_lost_o` is 1, `level_o` stays 0. Both stay as they are until a pulse arrives.
- R9: Pulses spaced with at most `TIMEOUT_CYCLES`-1 idle cycles between them never raise `link_lost_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pulse_i | input | 1 | One-cycle event commanding the level high |
| clr_pulse_i | input | 1 | One-cycle event commanding the level low |
| level_o | output | 1 | Reconstructed level |
| link_lost_o | output | 1 | High while the watchdog considers the transmitter dead |

## Verification
The assertions assume the two pulse inputs are synchronous to `clk` and free of X after reset. They also assume a pulse lasting several cycles is meant as that many separate events. The bench drives every input at the falling edge from a seeded generator. Its directed phases place pulse gaps exactly at `TIMEOUT_CYCLES`-1 and `TIMEOUT_CYCLES` idle cycles. Its random phase mixes short gaps, long gaps and simultaneous pulses, so the timeout boundary and the invalid-input case are both reached while the link is alive and after it is lost.

// File: rtl/isorx_pkg.sv
package isorx_pkg;

    // Classified pulse event for one clock cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_SET  = 2'd1,
        EV_CLR  = 2'd2,
        EV_BAD  = 2'd3
    } pulse_ev_e;

    // True when the event restarts the watchdog
    function automatic logic ev_is_pulse(input pulse_ev_e ev);
        return ev != EV_NONE;
    endfunction

endpackage

// File: rtl/isorx_pulse_classify.sv
module isorx_pulse_classify
    import isorx_pkg::*;
(
    input  logic      set_i,
    input  logic      clr_i,
    output pulse_ev_e ev_o
);

    always_comb begin
        unique case ({set_i, clr_i})
            2'b10:   ev_o = EV_SET;
            2'b01:   ev_o = EV_CLR;
            2'b11:   ev_o = EV_BAD;
            default: ev_o = EV_NONE;
        endcase
    end

endmodule

// File: rtl/isorx_watchdog.sv
module isorx_watchdog
    import isorx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 500
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pulse_ev_e ev_i,
    output logic      lost_d_o,
    output logic      lost_q_o
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

    typedef struct packed {
        logic [CW-1:0] idle;
        logic          lost;
    } wd_t;

    wd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev_is_pulse(ev_i)) begin
            st_d.idle = '0;
            st_d.lost = 1'b0;
        end else if (st_q.idle != LIMIT) begin
            st_d.idle = st_q.idle + 1'b1;
            st_d.lost = (st_d.idle == LIMIT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idle <= LIMIT;
            st_q.lost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lost_d_o = st_d.lost;
    assign lost_q_o = st_q.lost;

endmodule

// File: rtl/isorx_level_hold.sv
module isorx_level_hold
    import isorx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pulse_ev_e ev_i,
    input  logic      force_low_i,
    output logic      level_o
);

    typedef struct packed {
        logic level;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_low_i) begin
            st_d.level = 1'b0;
        end else begin
            unique case (ev_i)
                EV_SET:  st_d.level = 1'b1;
                EV_CLR:  st_d.level = 1'b0;
                default: st_d.level = st_q.level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.level <= 1'b0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

endmodule

// File: rtl/isorx_pulse_decoder.sv
module isorx_pulse_decoder
    import isorx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse_i,
    input  logic clr_pulse_i,
    output logic level_o,
    output logic link_lost_o
);

    pulse_ev_e ev;
    logic      lost_d;

    isorx_pulse_classify u_classify (
        .set_i (set_pulse_i),
        .clr_i (clr_pulse_i),
        .ev_o  (ev)
    );

    isorx_watchdog #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_watchdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .lost_d_o (lost_d),
        .lost_q_o (link_lost_o)
    );

    isorx_level_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev),
        .force_low_i (lost_d),
        .level_o     (level_o)
    );

endmodule

// File: rtl/isorx_pulse_decoder_chk.sv
module isorx_pulse_decoder_chk #(
    parameter int TIMEOUT_CYCLES = 500
) (
    input logic clk,
    input logic rst_n,
    input logic set_pulse_i,
    input logic clr_pulse_i,
    input logic level_o,
    input logic link_lost_o
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

    // Independent count of pulse-free cycles
    logic [CW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          gap_q <= CW'(TIMEOUT_CYCLES);
        else if (set_pulse_i || clr_pulse_i) gap_q <= '0;
        else if (gap_q != CW'(TIMEOUT_CYCLES)) gap_q <= gap_q + 1'b1;
    end

    assert_set_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse_i && !clr_pulse_i) |=> level_o);

    assert_clr_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse_i && !set_pulse_i) |=> !level_o);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_pulse_i && !clr_pulse_i) |=> (level_o == $past(level_o)) || link_lost_o);

    assert_gap_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost_o == (gap_q == CW'(TIMEOUT_CYCLES)));

    assert_pulse_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse_i || clr_pulse_i) |=> !link_lost_o);

    assert_conflict_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse_i && clr_pulse_i) |=> $stable(level_o));

    assert_lost_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost_o |-> !level_o);

    assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_lost_o && !set_pulse_i && !clr_pulse_i) |=> link_lost_o);

endmodule

bind isorx_pulse_decoder isorx_pulse_decoder_chk #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_pulse_i (set_pulse_i),
    .clr_pulse_i (clr_pulse_i),
    .level_o     (level_o),
    .link_lost_o (link_lost_o)
);

// File: tb/isorx_pulse_decoder_tb.sv
`timescale 1ns/1ps
module isorx_pulse_decoder_tb;

    localparam int TMO = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_p = 1'b0;
    logic clr_p = 1'b0;
    logic level, lost;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Behavioural reference
    bit m_level;
    bit m_lost;
    int m_gap;

    always #5 clk = ~clk;

    isorx_pulse_decoder #(.TIMEOUT_CYCLES(TMO)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_pulse_i (set_p),
        .clr_pulse_i (clr_p),
        .level_o     (level),
        .link_lost_o (lost)
    );

    task automatic check(input string req, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle at a falling edge, step the model, compare at the next falling edge
    task automatic cyc(input bit s, input bit c);
        string req_l, req_f;
        set_p = s;
        clr_p = c;
        if (s || c) begin
            m_gap  = 0;
            m_lost = 0;
            if (s && !c) begin m_level = 1; req_l = "R1"; end
            else if (c && !s) begin m_level = 0; req_l = "R2"; end
            else req_l = "R6";
            req_f = "R5";
        end else begin
            if (m_gap < TMO) m_gap++;
            if (m_gap >= TMO) begin
                req_l = m_lost ? "R8" : "R4";
                m_lost = 1;
                m_level = 0;
            end else begin
                req_l = "R3";
            end
            req_f = (m_gap >= TMO) ? req_l : "R9";
        end
        @(negedge clk);
        check(req_l, "level_o", level, m_level);
        check(req_f, "link_lost_o", lost, m_lost);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7", "level_o in reset", level, 1'b0);
        check("R7", "link_lost_o in reset", lost, 1'b1);
        rst_n = 1'b1;
        m_level = 0; m_lost = 1; m_gap = TMO;
        @(negedge clk);
        check("R7", "level_o after reset", level, 1'b0);
        check("R7", "link_lost_o after reset", lost, 1'b1);

        idle(3);                 // R8: still lost
        cyc(1, 0);               // R1, R5
        idle(10);                // R3
        cyc(0, 1);               // R2
        cyc(1, 0);
        cyc(1, 1);               // R6: holds high
        idle(4);
        cyc(0, 1);
        cyc(1, 1);               // R6: holds low

        // R9: healthy refresh, gaps up to TMO-1
        for (int k = 0; k < 20; k++) begin
            idle((k % 2) ? TMO - 1 : 100);
            cyc(k[0], ~k[0]);
        end
        cyc(1, 0);
        idle(TMO - 1);           // R4: not yet lost
        idle(1);                 // R4: lost now, level forced low
        idle(20);                // R8
        cyc(1, 1);               // R6 on lost link: clears flag, level stays 0
        cyc(1, 0);
        idle(TMO + 5);           // R4 from high level

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int gap = ($urandom_range(0, 9) == 0) ? $urandom_range(TMO - 2, TMO + 3)
                                                  : $urandom_range(0, 40);
            idle(gap);
            case ($urandom_range(0, 3))
                0: cyc(1, 1);
                1, 2: cyc(1, 0);
                default: cyc(0, 1);
            endcase
        end
        set_p = 0; clr_p = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule